// File: doc/BRIEF.md
# Magnitude Scaler with Windowed Average

The block takes a wide signed sample each time its input strobe is high. It forms the absolute value of the sample and shifts that magnitude right by a fixed amount to obtain a narrow unsigned level. It then keeps the average of the most recent 1024 levels. The block is meant to sit behind a filter, to turn its output into a slowly varying strength reading.

The average is not recomputed from scratch. A running sum is kept in an accumulator wide enough for a full window. Each new level is added to it, and the level that leaves the window is taken away. The window itself is a single-port-write, synchronous-read memory used as a ring. The slot that the new level will overwrite is read one cycle before that write, so the leaving value is fetched first. Until the ring has wrapped once, the leaving value is taken as zero. Both the scaling and the averaging are power-of-two shifts.

Each accepted sample produces exactly one output strobe, two clock edges later. The strobe carries the sample's full magnitude and the updated average. Cycles with the strobe low change nothing.

Top module: `mag_avg_top`

## Requirements
- R1: While rst_i is high and on the cycle after it is released, valid_o is 0, mag_o is 0 and avg_o is 0.
- R2: valid_o is high for one cycle, two rising edges after each rising edge at which valid_i was high, and is never high otherwise. Samples may arrive on every cycle.
- R3: mag_o is the absolute value of the two's-complement sample_i, given as an IN_W-bit unsigned number. The most negative input gives 2^(IN_W-1) without overflow.
- R4: The level of a sample is floor(mag / 2^SHIFT), clamped to 2^SCL_W-1. With the default widths the clamp is never reached.
- R5: avg_o is floor(S / 2^AW), where S is the sum of the levels of the last min(n, 2^AW) accepted samples and n is the number accepted since reset.
- R6: Once more than 2^AW samples have been accepted, each new sample removes the oldest level from S. A run of 2^AW zero samples therefore brings avg_o back to 0.
- R7: A cycle with valid_i low has no effect. It produces no strobe, avg_o and mag_o hold, and the window keeps its contents.
- R8: The running sum never exceeds 2^AW·(2^SCL_W-1), and avg_o never exceeds 2^SCL_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Sample strobe |
| sample_i | input | IN_W | Signed input sample |
| valid_o | output | 1 | Result strobe, one cycle per accepted sample |
| mag_o | output | IN_W | Absolute value of the sample |
| avg_o | output | SCL_W | Average level over the window |

## Verification
Directed samples cover both signs, zero, minus one, values just under one level step, and the most negative code. Together they separate a correct absolute value from a one's-complement value and from an overflowing one. A burst of more than a full window of most-negative samples drives the sum to its ceiling. A following full window of zeros must bring the average back to zero, which only happens if the oldest entries are really subtracted. Random samples with random widths and random idle gaps, including back-to-back strobes, check the strobe timing, the hold during idle cycles and the ring addressing against a model kept in the bench.

// File: rtl/mag_avg_pkg.sv
package mag_avg_pkg;
  localparam int DEF_IN_W  = 38;
  localparam int DEF_SHIFT = 20;
  localparam int DEF_SCL_W = 18;
  localparam int DEF_AW    = 10;

  // accumulator width needed for a full window of levels
  function automatic int sum_width(input int scl_w, input int aw);
    return scl_w + aw;
  endfunction
endpackage

// File: rtl/mag_front.sv
module mag_front #(
  parameter int IN_W  = mag_avg_pkg::DEF_IN_W,
  parameter int SHIFT = mag_avg_pkg::DEF_SHIFT,
  parameter int SCL_W = mag_avg_pkg::DEF_SCL_W
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  sample_i,
  output logic             s1_valid_o,
  output logic [IN_W-1:0]  s1_mag_o,
  output logic [SCL_W-1:0] s1_level_o
);
  localparam logic [IN_W-1:0] LEVEL_MAX = IN_W'((64'(1) << SCL_W) - 64'(1));

  // absolute value; the most negative code maps to 2^(IN_W-1) as unsigned
  function automatic logic [IN_W-1:0] abs_val(input logic [IN_W-1:0] x);
    return x[IN_W-1] ? (~x + IN_W'(1)) : x;
  endfunction

  // shift down and clamp into the level width
  function automatic logic [SCL_W-1:0] to_level(input logic [IN_W-1:0] m);
    logic [IN_W-1:0] t;
    t = m >> SHIFT;
    if (t > LEVEL_MAX) return LEVEL_MAX[SCL_W-1:0];
    return t[SCL_W-1:0];
  endfunction

  logic [IN_W-1:0] mag_c;
  assign mag_c = abs_val(sample_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      s1_valid_o <= 1'b0;
      s1_mag_o   <= '0;
      s1_level_o <= '0;
    end else begin
      s1_valid_o <= valid_i;
      if (valid_i) begin
        s1_mag_o   <= mag_c;
        s1_level_o <= to_level(mag_c);
      end
    end
  end
endmodule

// File: rtl/ring_store.sv
module ring_store #(
  parameter int DW = mag_avg_pkg::DEF_SCL_W,
  parameter int AW = mag_avg_pkg::DEF_AW
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          adv_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] old_o,
  output logic          old_live_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] wr_addr_q;
  logic          full_q;

  // storage: read the slot that is about to be overwritten, write one cycle later
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_q] <= wr_data_i;
    if (adv_i)   old_o <= mem[ptr_q];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ptr_q      <= '0;
      wr_addr_q  <= '0;
      full_q     <= 1'b0;
      old_live_o <= 1'b0;
    end else if (adv_i) begin
      wr_addr_q  <= ptr_q;
      ptr_q      <= ptr_q + AW'(1);
      old_live_o <= full_q;
      if (ptr_q == AW'(DEPTH - 1)) full_q <= 1'b1;
    end
  end
endmodule

// File: rtl/run_sum.sv
module run_sum #(
  parameter int IN_W  = mag_avg_pkg::DEF_IN_W,
  parameter int SCL_W = mag_avg_pkg::DEF_SCL_W,
  parameter int AW    = mag_avg_pkg::DEF_AW
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic                   s1_valid_i,
  input  logic [IN_W-1:0]        s1_mag_i,
  input  logic [SCL_W-1:0]       add_i,
  input  logic [SCL_W-1:0]       sub_i,
  output logic [SCL_W+AW-1:0]    sum_o,
  output logic                   valid_o,
  output logic [IN_W-1:0]        mag_o,
  output logic [SCL_W-1:0]       avg_o
);
  localparam int SUM_W = mag_avg_pkg::sum_width(SCL_W, AW);

  function automatic logic [SUM_W-1:0] step_sum(input logic [SUM_W-1:0] s,
                                                input logic [SCL_W-1:0] a,
                                                input logic [SCL_W-1:0] d);
    return s + SUM_W'(a) - SUM_W'(d);
  endfunction

  function automatic logic [SCL_W-1:0] window_avg(input logic [SUM_W-1:0] s);
    return s[SUM_W-1:AW];
  endfunction

  logic [SUM_W-1:0] next_c;
  assign next_c = step_sum(sum_o, add_i, sub_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sum_o   <= '0;
      valid_o <= 1'b0;
      mag_o   <= '0;
      avg_o   <= '0;
    end else begin
      valid_o <= s1_valid_i;
      if (s1_valid_i) begin
        sum_o <= next_c;
        mag_o <= s1_mag_i;
        avg_o <= window_avg(next_c);
      end
    end
  end
endmodule

// File: rtl/mag_avg_top.sv
module mag_avg_top #(
  parameter int IN_W  = mag_avg_pkg::DEF_IN_W,
  parameter int SHIFT = mag_avg_pkg::DEF_SHIFT,
  parameter int SCL_W = mag_avg_pkg::DEF_SCL_W,
  parameter int AW    = mag_avg_pkg::DEF_AW
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  sample_i,
  output logic             valid_o,
  output logic [IN_W-1:0]  mag_o,
  output logic [SCL_W-1:0] avg_o
);
  localparam int SUM_W = mag_avg_pkg::sum_width(SCL_W, AW);

  // named internal events, visible to the bound checker
  logic             s1_valid;
  logic [IN_W-1:0]  s1_mag;
  logic [SCL_W-1:0] s1_level;
  logic [SCL_W-1:0] old_raw;
  logic             old_live;
  logic [SCL_W-1:0] evict_val;
  logic [SUM_W-1:0] sum_q;

  mag_front #(.IN_W(IN_W), .SHIFT(SHIFT), .SCL_W(SCL_W)) u_front (
    .clk_i(clk_i), .rst_i(rst_i), .valid_i(valid_i), .sample_i(sample_i),
    .s1_valid_o(s1_valid), .s1_mag_o(s1_mag), .s1_level_o(s1_level)
  );

  ring_store #(.DW(SCL_W), .AW(AW)) u_ring (
    .clk_i(clk_i), .rst_i(rst_i), .adv_i(valid_i),
    .wr_en_i(s1_valid), .wr_data_i(s1_level),
    .old_o(old_raw), .old_live_o(old_live)
  );

  // before the ring has wrapped, nothing leaves the window
  assign evict_val = old_live ? old_raw : '0;

  run_sum #(.IN_W(IN_W), .SCL_W(SCL_W), .AW(AW)) u_sum (
    .clk_i(clk_i), .rst_i(rst_i), .s1_valid_i(s1_valid), .s1_mag_i(s1_mag),
    .add_i(s1_level), .sub_i(evict_val), .sum_o(sum_q),
    .valid_o(valid_o), .mag_o(mag_o), .avg_o(avg_o)
  );
endmodule

// File: rtl/mag_avg_chk.sv
module mag_avg_chk #(
  parameter int IN_W  = 38,
  parameter int SCL_W = 18,
  parameter int AW    = 10
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic                valid_i,
  input logic                s1_valid,
  input logic [SCL_W+AW-1:0] sum_q,
  input logic                valid_o,
  input logic [IN_W-1:0]     mag_o,
  input logic [SCL_W-1:0]    avg_o
);
  localparam int SUM_W = SCL_W + AW;
  localparam logic [SUM_W-1:0] SUM_MAX =
    SUM_W'(((64'(1) << SCL_W) - 64'(1)) << AW);

  AST_STROBE_TIMING: assert property (@(posedge clk_i) disable iff (rst_i)
    s1_valid == $past(valid_i));                                   // R2
  AST_STROBE_FOLLOWS: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o == $past(s1_valid));                                   // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !s1_valid |=> ($stable(avg_o) && $stable(mag_o) && !valid_o)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (rst_i)
    sum_q <= SUM_MAX);                                             // R8
  AST_AVG_MATCHES_SUM: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |-> (avg_o == sum_q[SUM_W-1:AW]));                     // R5
endmodule

bind mag_avg_top mag_avg_chk #(.IN_W(IN_W), .SCL_W(SCL_W), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .valid_i(valid_i), .s1_valid(s1_valid),
  .sum_q(sum_q), .valid_o(valid_o), .mag_o(mag_o), .avg_o(avg_o)
);

// File: tb/mag_avg_top_tb.sv
module mag_avg_top_tb;
  localparam int IN_W = 38, SHIFT = 20, SCL_W = 18, AW = 10;
  localparam int WIN = 1 << AW;
  localparam int MAXN = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid_i = 1'b0;
  logic [IN_W-1:0] sample_i = '0;
  logic valid_o;
  logic [IN_W-1:0] mag_o;
  logic [SCL_W-1:0] avg_o;

  always #10 clk = ~clk;  // 50 MHz

  mag_avg_top #(.IN_W(IN_W), .SHIFT(SHIFT), .SCL_W(SCL_W), .AW(AW)) u_dut (
    .clk_i(clk), .rst_i(rst), .valid_i(valid_i), .sample_i(sample_i),
    .valid_o(valid_o), .mag_o(mag_o), .avg_o(avg_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model
  longint hist [MAXN];
  longint model_sum = 0;
  int n_sent = 0;
  int n_seen = 0;
  logic [IN_W-1:0] exp_mag [MAXN];
  logic [SCL_W-1:0] exp_avg [MAXN];

  function automatic logic [IN_W-1:0] ref_mag(input logic [IN_W-1:0] x);
    logic signed [IN_W:0] w;
    w = $signed({x[IN_W-1], x});
    if (w < 0) w = -w;
    return w[IN_W-1:0];
  endfunction

  function automatic longint ref_level(input logic [IN_W-1:0] m);
    longint v;
    v = longint'(m) / (longint'(1) << SHIFT);
    if (v > (longint'(1) << SCL_W) - 1) v = (longint'(1) << SCL_W) - 1;
    return v;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_model(input logic [IN_W-1:0] x);
    logic [IN_W-1:0] m;
    longint lv;
    m = ref_mag(x);
    lv = ref_level(m);
    hist[n_sent] = lv;
    model_sum += lv;
    if (n_sent >= WIN) model_sum -= hist[n_sent - WIN];
    exp_mag[n_sent] = m;
    exp_avg[n_sent] = SCL_W'(model_sum / WIN);
    n_sent++;
  endtask

  // drive one sample, optionally followed by idle cycles with garbage data
  task automatic send(input logic [IN_W-1:0] x, input int gap);
    @(negedge clk);
    valid_i = 1'b1;
    sample_i = x;
    push_model(x);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      valid_i = 1'b0;
      sample_i = {$urandom, $urandom};
    end
  endtask

  task automatic flush();
    @(negedge clk);
    valid_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // expected strobe: two edges after each sampled valid_i
  logic vp0 = 1'b0, vp1 = 1'b0;
  always @(posedge clk) begin
    vp0 <= rst ? 1'b0 : valid_i;
    vp1 <= rst ? 1'b0 : vp0;
  end

  logic [SCL_W-1:0] last_avg = '0;
  logic [IN_W-1:0] last_mag = '0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (valid_o || vp1) check("R2 strobe", valid_o, vp1);
      if (valid_o) begin
        if (n_seen < n_sent) begin
          check("R3 magnitude", mag_o, exp_mag[n_seen]);
          check("R5 average", avg_o, exp_avg[n_seen]);
        end else check("R2 extra strobe", 1, 0);
        n_seen++;
        last_avg = avg_o;
        last_mag = mag_o;
      end else if (vp0 == 1'b0) begin
        // R7: idle cycle leaves outputs untouched
        if (avg_o != last_avg || mag_o != last_mag) check("R7 hold", avg_o, last_avg);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 valid_o in reset", valid_o, 0);
    check("R1 mag_o in reset", mag_o, 0);
    check("R1 avg_o in reset", avg_o, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid_o after reset", valid_o, 0);
    check("R1 avg_o after reset", avg_o, 0);

    // R3/R4 directed corners
    send({1'b1, {(IN_W-1){1'b0}}}, 1);      // most negative
    send({1'b0, {(IN_W-1){1'b1}}}, 2);      // most positive
    send('0, 1);                            // zero
    send({IN_W{1'b1}}, 1);                  // minus one
    send(IN_W'((64'(1) << SHIFT) - 1), 1);  // just under one level
    send(IN_W'(64'(1) << SHIFT), 1);        // exactly one level
    send(-IN_W'(64'(1) << SHIFT), 3);       // minus one level
    flush();
    check("R4 level one reaches avg", n_seen, n_sent);

    // R8: fill past a full window with full-scale samples, back to back (R2)
    for (int i = 0; i < WIN + 80; i++) send({1'b1, {(IN_W-1){1'b0}}}, 0);
    flush();
    check("R8 avg at ceiling", avg_o, (1 << (SCL_W-1)));

    // R6: a full window of zeros drains the average
    for (int i = 0; i < WIN; i++) send('0, (i % 7 == 0) ? 2 : 0);
    flush();
    check("R6 avg drained to zero", avg_o, 0);

    // random widths, signs and gaps
    for (int i = 0; i < 2400; i++) begin
      logic [IN_W-1:0] x;
      x = {$urandom, $urandom};
      x = $signed(x) >>> ($urandom % 30);
      send(x, ($urandom % 4 == 0) ? int'($urandom % 5) : 0);
    end
    flush();
    check("R2 all samples answered", n_seen, n_sent);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule